// File: doc/BRIEF.md
# Second-Level Cache Tag Lookup with Line Ownership

This block holds the tag side of a four-way set-associative second-level cache. Each line stores a tag, a valid bit and an ownership marker that says the cache holds the line exclusively. A lookup request carries a byte address and a command class. The block indexes one set, compares the tags of all four ways in parallel and resolves the request into one of three results. A hit returns the line in shared or exclusive mode. An upgrade miss means the line is present, but only in shared mode, and the requester wants ownership. A full miss means no way matches.

On a full miss the block names the way that a refill should replace. An invalid way is taken before the pseudo-LRU choice. The block also flags whether the displaced line must be written back, and rebuilds that line's address. Refills arrive on a separate install input. The install writes the tag and the ownership marker into a chosen way and marks that way as most recently used. Misses are answered in the request cycle. Hits are answered after a fixed, parameterised latency.

Top module: `l2_tag_lookup`

## Requirements
- R1: After reset every way of every set is invalid and every set's replacement state is zero, so the first lookup to any address is a full miss that names way 0 and requests no writeback.
- R2: The tag compare ignores the ownership marker. A shared read (command 2'b00) that matches an owned line is a hit in exclusive mode.
- R3: A command needing ownership (2'b01 exclusive read, 2'b10 upgrade, 2'b11 treated as exclusive read) that matches a line without the ownership marker gives an upgrade miss naming the matching way, and no hit.
- R4: The hit mode output is 1 when the matching line carries the ownership marker and 0 otherwise. A shared read of an unowned line is a shared hit.
- R5: A hit appears on the hit outputs exactly HIT_LAT clock cycles after the cycle in which the request was presented (default 2), and never earlier. When HIT_LAT is 0 it appears in the request cycle.
- R6: A miss, of either kind, is reported combinationally in the request cycle and produces no later hit.
- R7: On a full miss, when any way of the set is invalid, the lowest-numbered invalid way is named as victim.
- R8: On a full miss with all four ways valid, the victim follows the tree state (bit 0 root, bit 1 ways 0/1, bit 2 ways 2/3). A root of 0 selects the pair of ways 0 and 1, and a root of 1 selects the pair of ways 2 and 3. Within the selected pair, a pair bit of 0 selects the lower way and 1 selects the higher way.
- R9: The writeback flag is set only on a full miss whose victim is valid and owned. In that case the victim address is {victim tag, set index, zero offset}. Otherwise the victim address output is zero.
- R10: A hit marks the hit way most recently used. The root and that way's pair bit are set to point away from it.
- R11: An install writes the tag and ownership marker into the given way, makes it valid, and marks it most recently used. Later lookups see the new line, and the old tag in that way misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Lookup request present this cycle |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqCmd | input | 2 | 00 shared read, 01 exclusive read, 10 upgrade, 11 exclusive read |
| fillValid | input | 1 | Install a line this cycle |
| fillAddr | input | ADDR_W | Byte address of the installed line |
| fillWay | input | 2 | Way written by the install |
| fillExcl | input | 1 | Ownership marker stored with the installed tag |
| missValid | output | 1 | Request missed (combinational) |
| missUpgrade | output | 1 | 1 for an upgrade miss, 0 for a full miss |
| missWay | output | 2 | Matching way (upgrade) or victim way (full miss) |
| missWriteback | output | 1 | Victim is owned and must be written back |
| missVictimAddr | output | ADDR_W | Line address of the victim when writeback is set, else zero |
| hitValid | output | 1 | Delayed hit response |
| hitExcl | output | 1 | Hit mode: 1 exclusive, 0 shared |
| hitWay | output | 2 | Way that hit |

## Verification
Lookups are issued with each of the four command codes against unowned lines, owned lines and absent tags, so that hits, upgrade misses and full misses are each told apart. A set is filled way by way to show that invalid ways are preferred. It is then filled completely with mixed ownership, and a chain of hits and installs steers the tree, showing that each hit and each install moves the victim to the predicted way. Each full miss is checked for its writeback flag and rebuilt address, both for owned and for unowned victims. Nonzero offset bits in the request address are used to show that the offset does not take part in the match.

// File: rtl/l2_tag_pkg.sv
package l2_tag_pkg;

  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [1:0] {
    CMD_SHARED   = 2'b00,
    CMD_EXCL     = 2'b01,
    CMD_UPGRADE  = 2'b10,
    CMD_EXCL_ALT = 2'b11
  } reqCmd_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic             touchEn;
    logic [WAY_W-1:0] touchWay;
    logic             installEn;
  } tagStrobes_t;

  typedef struct packed {
    logic             vld;
    logic             excl;
    logic [WAY_W-1:0] way;
  } hitRsp_t;

  // Tree state: [0] root, [1] pair of ways 0/1, [2] pair of ways 2/3.
  // Each bit points at the side that should be replaced next.
  function automatic logic [2:0] plruTouch(logic [2:0] cur, logic [WAY_W-1:0] way);
    logic [2:0] nxt;
    nxt    = cur;
    nxt[0] = ~way[1];
    if (!way[1]) nxt[1] = ~way[0];
    else         nxt[2] = ~way[0];
    return nxt;
  endfunction

  function automatic logic [WAY_W-1:0] plruVictim(logic [2:0] cur);
    return cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};
  endfunction

endpackage

// File: rtl/l2_tag_store.sv
module l2_tag_store
  import l2_tag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SET_W  = 6,
  parameter int OFF_W  = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-OFF_W-1:0] lookLine,
  input  logic [ADDR_W-OFF_W-1:0] fillLine,
  input  logic [WAY_W-1:0]        fillWay,
  input  logic                    fillExcl,
  input  tagStrobes_t             strobes,
  output logic                    matchAny,
  output logic [WAY_W-1:0]        matchWay,
  output logic                    matchExcl,
  output logic [WAY_W-1:0]        victimWay,
  output logic                    victimDirty,
  output logic [ADDR_W-1:0]       victimAddr
);

  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;

  logic [TAG_W-1:0] tagMem   [SETS][WAYS];
  logic             validMem [SETS][WAYS];
  logic             exclMem  [SETS][WAYS];
  logic [2:0]       plruMem  [SETS];

  logic [SET_W-1:0] lookSet, fillSet;
  logic [TAG_W-1:0] lookTag, fillTag;

  assign lookSet = lookLine[SET_W-1:0];
  assign lookTag = lookLine[ADDR_W-OFF_W-1:SET_W];
  assign fillSet = fillLine[SET_W-1:0];
  assign fillTag = fillLine[ADDR_W-OFF_W-1:SET_W];

  logic [WAYS-1:0] hitVec, emptyVec;

  // The ownership marker lives in its own bit, so it never enters the compare
  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign hitVec[w]   = validMem[lookSet][w] && (tagMem[lookSet][w] == lookTag);
      assign emptyVec[w] = !validMem[lookSet][w];
    end
  endgenerate

  always_comb begin
    matchWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) matchWay = WAY_W'(w);
    end
  end

  assign matchAny  = |hitVec;
  assign matchExcl = exclMem[lookSet][matchWay];

  logic [WAY_W-1:0] firstEmpty;
  always_comb begin
    firstEmpty = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (emptyVec[w]) firstEmpty = WAY_W'(w);
    end
  end

  assign victimWay   = (|emptyVec) ? firstEmpty : plruVictim(plruMem[lookSet]);
  assign victimDirty = validMem[lookSet][victimWay] && exclMem[lookSet][victimWay];
  assign victimAddr  = {tagMem[lookSet][victimWay], lookSet, {OFF_W{1'b0}}};

  // State flags and replacement state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        plruMem[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          validMem[s][w] <= 1'b0;
          exclMem[s][w]  <= 1'b0;
        end
      end
    end else begin
      if (strobes.installEn) begin
        validMem[fillSet][fillWay] <= 1'b1;
        exclMem[fillSet][fillWay]  <= fillExcl;
      end
      if (strobes.touchEn && strobes.installEn && (fillSet == lookSet)) begin
        plruMem[lookSet] <= plruTouch(plruTouch(plruMem[lookSet], strobes.touchWay), fillWay);
      end else begin
        if (strobes.touchEn)
          plruMem[lookSet] <= plruTouch(plruMem[lookSet], strobes.touchWay);
        if (strobes.installEn)
          plruMem[fillSet] <= plruTouch(plruMem[fillSet], fillWay);
      end
    end
  end

  // Tags need no reset: the valid bits guard them
  always_ff @(posedge clk) begin
    if (strobes.installEn) tagMem[fillSet][fillWay] <= fillTag;
  end

endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl
  import l2_tag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int HIT_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqCmd,
  input  logic              fillValid,
  input  logic              matchAny,
  input  logic [WAY_W-1:0]  matchWay,
  input  logic              matchExcl,
  input  logic [WAY_W-1:0]  victimWay,
  input  logic              victimDirty,
  input  logic [ADDR_W-1:0] victimAddr,
  output tagStrobes_t       strobes,
  output logic              missValid,
  output logic              missUpgrade,
  output logic [WAY_W-1:0]  missWay,
  output logic              missWriteback,
  output logic [ADDR_W-1:0] missVictimAddr,
  output logic              hitValid,
  output logic              hitExcl,
  output logic [WAY_W-1:0]  hitWay
);

  logic needOwn, hitNow, upgNow, fullNow;

  assign needOwn = (reqCmd_e'(reqCmd) != CMD_SHARED);
  assign hitNow  = reqValid && matchAny && (!needOwn || matchExcl);
  assign upgNow  = reqValid && matchAny && needOwn && !matchExcl;
  assign fullNow = reqValid && !matchAny;

  assign strobes.touchEn   = hitNow;
  assign strobes.touchWay  = matchWay;
  assign strobes.installEn = fillValid;

  assign missValid      = upgNow || fullNow;
  assign missUpgrade    = upgNow;
  assign missWay        = upgNow ? matchWay : (fullNow ? victimWay : '0);
  assign missWriteback  = fullNow && victimDirty;
  assign missVictimAddr = missWriteback ? victimAddr : '0;

  hitRsp_t hitIn, hitOut;
  assign hitIn.vld  = hitNow;
  assign hitIn.excl = hitNow && matchExcl;
  assign hitIn.way  = hitNow ? matchWay : '0;

  generate
    if (HIT_LAT == 0) begin : g_nodelay
      assign hitOut = hitIn;
    end else begin : g_delay
      hitRsp_t pipe [HIT_LAT];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < HIT_LAT; i++) pipe[i] <= '0;
        end else begin
          pipe[0] <= hitIn;
          for (int i = 1; i < HIT_LAT; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign hitOut = pipe[HIT_LAT-1];
    end
  endgenerate

  assign hitValid = hitOut.vld;
  assign hitExcl  = hitOut.excl;
  assign hitWay   = hitOut.way;

endmodule

// File: rtl/l2_tag_lookup.sv
module l2_tag_lookup
  import l2_tag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SET_W   = 6,
  parameter int OFF_W   = 6,
  parameter int HIT_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqCmd,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [1:0]        fillWay,
  input  logic              fillExcl,
  output logic              missValid,
  output logic              missUpgrade,
  output logic [1:0]        missWay,
  output logic              missWriteback,
  output logic [ADDR_W-1:0] missVictimAddr,
  output logic              hitValid,
  output logic              hitExcl,
  output logic [1:0]        hitWay
);

  tagStrobes_t      strobes;
  logic             matchAny, matchExcl, victimDirty;
  logic [WAY_W-1:0] matchWay, victimWay;
  logic [ADDR_W-1:0] victimAddr;
  logic             unusedOffsetBits;

  assign unusedOffsetBits = ^{reqAddr[OFF_W-1:0], fillAddr[OFF_W-1:0]};

  l2_tag_store #(
    .ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)
  ) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .lookLine   (reqAddr[ADDR_W-1:OFF_W]),
    .fillLine   (fillAddr[ADDR_W-1:OFF_W]),
    .fillWay    (fillWay),
    .fillExcl   (fillExcl),
    .strobes    (strobes),
    .matchAny   (matchAny),
    .matchWay   (matchWay),
    .matchExcl  (matchExcl),
    .victimWay  (victimWay),
    .victimDirty(victimDirty),
    .victimAddr (victimAddr)
  );

  l2_tag_ctrl #(
    .ADDR_W(ADDR_W), .HIT_LAT(HIT_LAT)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqCmd        (reqCmd),
    .fillValid     (fillValid),
    .matchAny      (matchAny),
    .matchWay      (matchWay),
    .matchExcl     (matchExcl),
    .victimWay     (victimWay),
    .victimDirty   (victimDirty),
    .victimAddr    (victimAddr),
    .strobes       (strobes),
    .missValid     (missValid),
    .missUpgrade   (missUpgrade),
    .missWay       (missWay),
    .missWriteback (missWriteback),
    .missVictimAddr(missVictimAddr),
    .hitValid      (hitValid),
    .hitExcl       (hitExcl),
    .hitWay        (hitWay)
  );

endmodule

// File: rtl/l2_tag_lookup_chk.sv
module l2_tag_lookup_chk #(
  parameter int ADDR_W  = 32,
  parameter int SET_W   = 6,
  parameter int OFF_W   = 6,
  parameter int HIT_LAT = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqCmd,
  input logic              missValid,
  input logic              missUpgrade,
  input logic              missWriteback,
  input logic [ADDR_W-1:0] missVictimAddr,
  input logic              hitValid,
  input logic              hitExcl
);

  // History of requests, HIT_LAT cycles deep
  logic reqThen;
  generate
    if (HIT_LAT == 0) begin : g_h0
      assign reqThen = reqValid;
    end else begin : g_hn
      logic [HIT_LAT-1:0] reqHist;
      always_ff @(posedge clk) begin
        if (!rstN) reqHist <= '0;
        else       reqHist <= (reqHist << 1) | HIT_LAT'(reqValid);
      end
      assign reqThen = reqHist[HIT_LAT-1];
    end
  endgenerate

  // R5: every hit traces back to a request HIT_LAT cycles earlier
  p_hit_after_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> reqThen);

  // R6: a miss is only ever reported alongside its request
  p_miss_with_request_r6: assert property (@(posedge clk) disable iff (!rstN)
    missValid |-> reqValid);

  // R9: writeback belongs only to a full miss
  p_writeback_full_miss_r9: assert property (@(posedge clk) disable iff (!rstN)
    missWriteback |-> (missValid && !missUpgrade));

  // R9: rebuilt victim address keeps the request's set and a zero offset
  p_victim_addr_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    missWriteback |-> (missVictimAddr[OFF_W +: SET_W] == reqAddr[OFF_W +: SET_W]
                       && missVictimAddr[OFF_W-1:0] == '0));

  // R3: an upgrade miss needs a command that asks for ownership
  p_upgrade_needs_own_r3: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missUpgrade) |-> (reqCmd != 2'b00));

  // R4: exclusive mode only travels with a hit
  p_excl_only_on_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    hitExcl |-> hitValid);

endmodule

bind l2_tag_lookup l2_tag_lookup_chk #(
  .ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W), .HIT_LAT(HIT_LAT)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqAddr       (reqAddr),
  .reqCmd        (reqCmd),
  .missValid     (missValid),
  .missUpgrade   (missUpgrade),
  .missWriteback (missWriteback),
  .missVictimAddr(missVictimAddr),
  .hitValid      (hitValid),
  .hitExcl       (hitExcl)
);

// File: tb/l2_tag_lookup_test.sv
`timescale 1ns/1ps
module l2_tag_lookup_test;

  localparam int ADDR_W = 32;
  localparam int SET_W  = 6;
  localparam int OFF_W  = 6;
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqCmd = 2'b00;
  logic              fillValid = 1'b0;
  logic [ADDR_W-1:0] fillAddr = '0;
  logic [1:0]        fillWay = 2'b00;
  logic              fillExcl = 1'b0;
  logic              missValid, missUpgrade, missWriteback;
  logic [1:0]        missWay;
  logic [ADDR_W-1:0] missVictimAddr;
  logic              hitValid, hitExcl;
  logic [1:0]        hitWay;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  l2_tag_lookup uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqCmd(reqCmd),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillWay(fillWay), .fillExcl(fillExcl),
    .missValid(missValid), .missUpgrade(missUpgrade), .missWay(missWay),
    .missWriteback(missWriteback), .missVictimAddr(missVictimAddr),
    .hitValid(hitValid), .hitExcl(hitExcl), .hitWay(hitWay)
  );

  // Captured results of the last lookup
  logic       cMiss, cUpg, cWb, cHitNow, cHitEarly, cHit, cHitExcl;
  logic [1:0] cMissWay, cHitWay;
  logic [ADDR_W-1:0] cVicAddr;

  function automatic logic [ADDR_W-1:0] mkAddr(int tag, int set, int off);
    return {TAG_W'(tag), SET_W'(set), OFF_W'(off)};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(logic [ADDR_W-1:0] addr, logic [1:0] cmd);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqCmd = cmd;
    #1;
    cMiss = missValid; cUpg = missUpgrade; cMissWay = missWay;
    cWb = missWriteback; cVicAddr = missVictimAddr; cHitNow = hitValid;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    cHitEarly = hitValid;
    @(negedge clk);
    #1;
    cHit = hitValid; cHitExcl = hitExcl; cHitWay = hitWay;
  endtask

  task automatic install(int tag, int set, logic [1:0] way, logic excl);
    @(negedge clk);
    fillValid = 1'b1; fillAddr = mkAddr(tag, set, 0); fillWay = way; fillExcl = excl;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic expectFull(string req, logic [1:0] way, logic wb, logic [ADDR_W-1:0] vic);
    check(req, "miss", cMiss, 1);
    check(req, "upgrade", cUpg, 0);
    check(req, "victim way", cMissWay, way);
    check(req, "writeback", cWb, wb);
    check(req, "victim addr", cVicAddr, vic);
    check(req, "no hit", cHit | cHitEarly | cHitNow, 0);
  endtask

  task automatic expectHit(string req, logic [1:0] way, logic excl);
    check(req, "no miss", cMiss, 0);
    check(req, "hit not early", cHitNow | cHitEarly, 0);
    check(req, "hit", cHit, 1);
    check(req, "hit way", cHitWay, way);
    check(req, "hit mode", cHitExcl, excl);
  endtask

  task automatic expectUpgrade(string req, logic [1:0] way);
    check(req, "miss", cMiss, 1);
    check(req, "upgrade", cUpg, 1);
    check(req, "way", cMissWay, way);
    check(req, "writeback", cWb, 0);
    check(req, "no hit", cHit | cHitEarly | cHitNow, 0);
  endtask

  // R1: empty cache after reset
  task automatic testReset();
    #1;
    check("R1", "hit output idle", hitValid, 0);
    lookup(mkAddr(1, 5, 0), 2'b00);
    expectFull("R1", 2'd0, 0, '0);
  endtask

  // R7: lowest invalid way is the victim
  task automatic testEmptyFirst();
    install(1, 5, 2'd0, 0);
    lookup(mkAddr(2, 5, 0), 2'b00);
    expectFull("R7", 2'd1, 0, '0);
    install(3, 5, 2'd2, 1);
    lookup(mkAddr(4, 5, 8), 2'b01);
    expectFull("R7", 2'd1, 0, '0);
  endtask

  // R4, R5: shared hit with fixed latency; R2: marker ignored by compare
  task automatic testHits();
    lookup(mkAddr(1, 5, 0), 2'b00);
    expectHit("R5", 2'd0, 0);
    check("R4", "shared mode", cHitExcl, 0);
    lookup(mkAddr(3, 5, 6'h2c), 2'b00);
    expectHit("R2", 2'd2, 1);
  endtask

  // R3: ownership requests on unowned line; owned line hits
  task automatic testUpgrades();
    lookup(mkAddr(1, 5, 0), 2'b01);
    expectUpgrade("R3", 2'd0);
    lookup(mkAddr(1, 5, 4), 2'b10);
    expectUpgrade("R3", 2'd0);
    lookup(mkAddr(1, 5, 0), 2'b11);
    expectUpgrade("R3", 2'd0);
    lookup(mkAddr(3, 5, 0), 2'b10);
    expectHit("R4", 2'd2, 1);
    // R6: misses were answered in the request cycle only
    check("R6", "upgrade answered at once", cMiss, 0);
  endtask

  // R8, R9, R10, R11: full set, tree-driven victims
  task automatic testReplacement();
    install(10, 9, 2'd0, 1);
    install(11, 9, 2'd1, 0);
    install(12, 9, 2'd2, 1);
    install(13, 9, 2'd3, 0);
    // tree now 000 -> way 0
    lookup(mkAddr(20, 9, 0), 2'b00);
    expectFull("R8", 2'd0, 1, mkAddr(10, 9, 0));
    check("R9", "owned victim written back", cWb, 1);
    // hit way 0 -> victim way 2
    lookup(mkAddr(10, 9, 0), 2'b00);
    expectHit("R10", 2'd0, 1);
    lookup(mkAddr(21, 9, 0), 2'b01);
    expectFull("R10", 2'd2, 1, mkAddr(12, 9, 0));
    // hit way 2 -> victim way 1 (unowned)
    lookup(mkAddr(12, 9, 0), 2'b01);
    expectHit("R10", 2'd2, 1);
    lookup(mkAddr(22, 9, 0), 2'b00);
    expectFull("R9", 2'd1, 0, '0);
    // install way 1 owned -> victim way 3
    install(30, 9, 2'd1, 1);
    lookup(mkAddr(30, 9, 0), 2'b01);
    expectHit("R11", 2'd1, 1);
    lookup(mkAddr(23, 9, 0), 2'b00);
    expectFull("R11", 2'd3, 0, '0);
    lookup(mkAddr(11, 9, 0), 2'b00);
    check("R11", "old tag gone", cMiss, 1);
    check("R11", "old tag full miss", cUpg, 0);
    // R6: a miss never surfaces as a later hit
    check("R6", "no late hit", cHit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEmptyFirst();
    testHits();
    testUpgrades();
    testReplacement();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule